// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block acts as the master that loads a configuration bitstream into a downstream FPGA over a slave-serial link. When a load is requested, it first runs the device's reset handshake. It pulses the active-low program line, follows the open-drain init line down and back up, and confirms that the device's DONE line is low. It then waits a fixed programming latency. After that it shifts the bitstream bytes out on a divided serial clock and data pair, most significant bit first.

Bytes arrive on a valid/ready stream whose last byte carries an end marker. After the last byte the block keeps clocking. Each round samples DONE and then sends one all-ones byte. A round that saw DONE high ends the load with success. A completion timeout bounds this loop. After it expires, one last sample and pad are still made, and a failing load is then classified from the init line. Every load ends with a one-cycle finish pulse and a status code. The status code stays on the output until the next load ends.

All waits are counted in system-clock cycles, so the integrator sets them from the clock frequency: 1 s for each init wait, at least 500 ns for the program pulse, and about 7.5 ms for the latency. A parameter states whether the init line is wired at all.

Top module: `cfg_loader`

## Requirements
- R1: A start request with `partial_i` high ends at once with status 1 (unsupported), a finish pulse and no low pulse on `prog_n_o`. No start request toggles any pin unless `partial_i` is low.
- R2: With the init line present, `prog_n_o` goes low on an accepted start and stays low until the synchronised init line reads low. No stream byte is accepted while `prog_n_o` is low.
- R3: With no init line (`HAS_INIT`=0), `prog_n_o` is held low for exactly `PULSE_CYC` cycles. The block then goes on without looking at `init_n_i`.
- R4: If the init line does not fall within `INIT_TMO_CYC` cycles of program going low, the load fails with status 2 (init timeout). The same happens if it does not rise within `INIT_TMO_CYC` cycles of program being released. In both cases `prog_n_o` is high at the finish.
- R5: Once the handshake is complete, a high DONE ends the load with status 3 (I/O error) before any clock edge on `cclk_o`.
- R6: The first rising edge of `cclk_o` comes at least `LAT_CYC` cycles after the init line returned high.
- R7: Each byte is sent most significant bit first, in eight `cclk_o` periods of 2*`CLK_DIV` system cycles each. `din_o` changes only when `cclk_o` falls or a new byte is loaded.
- R8: After the byte marked last, each round samples DONE and then sends 0xFF. A round whose sample saw DONE high ends the load with status 0 once its pad is sent, so exactly one pad follows the round in which DONE is first seen.
- R9: When `DONE_TMO_CYC` cycles have passed since the last byte was accepted, one more round is made. If that round also fails, the status is 4 (CRC or wrong device) with the init line low, 5 (incomplete bitstream) with it high, or 6 (plain timeout) with no init line.
- R10: `fin_o` is a one-cycle pulse. `status_o` changes only together with it. Start requests during a load are ignored.
- R11: After reset `prog_n_o` is high, `cclk_o` is low, and `busy_o`, `fin_o`, `s_ready_o` and `status_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request, one cycle |
| partial_i | input | 1 | Partial-reconfiguration flag for the request |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_ready_o | output | 1 | Byte accepted when high with valid |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| prog_n_o | output | 1 | Active-low program request |
| init_n_i | input | 1 | Init line from the device (active low) |
| done_i | input | 1 | DONE line from the device |
| busy_o | output | 1 | A load is in progress |
| fin_o | output | 1 | One-cycle pulse when a load ends |
| status_o | output | 3 | Result code, held until the next load ends |

## Verification
A table of loads is run against a small device model. The model can answer the handshake normally, never pull init low, hold init low, show DONE already high, drop init after the data, or raise DONE after a chosen number of pads. Together these separate every status code. DONE rising after zero, one and two pads pins down that exactly one pad follows the sample that saw it. Loads that never finish show that the final sample and pad come after the timeout and that the init level picks the code. A second instance without an init line, whose init input is tied low, shows that the fixed pulse replaces both init waits.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_OK       = 3'd0,
    ST_UNSUP    = 3'd1,
    ST_INIT_TMO = 3'd2,
    ST_IO_ERR   = 3'd3,
    ST_CRC      = 3'd4,
    ST_TRUNC    = 3'd5,
    ST_TMO      = 3'd6
  } cfg_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_INITHI, S_CHKDONE, S_LAT, S_DATA, S_PADGO, S_PADWAIT
  } cfg_fsm_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       ready_o,
  output logic       cclk_o,
  output logic       din_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(DIV - 1);

  logic          active_q, cclk_q, din_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] dc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cclk_q   <= 1'b0;
      din_q    <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      dc_q     <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cclk_q   <= 1'b0;
      din_q    <= byte_i[7];
      sh_q     <= byte_i;
      bit_q    <= '0;
      dc_q     <= '0;
    end else if (active_q) begin
      if (dc_q == DIV_END) begin
        dc_q <= '0;
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          cclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 3'd1;
            din_q <= sh_q[6];
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        dc_q <= dc_q + DW'(1);
      end
    end
  end

  assign ready_o = !active_q;
  assign cclk_o  = cclk_q;
  assign din_o   = din_q;

  // R7: data moves only on a falling serial clock or a fresh load
  p_din_edge_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(din_o) |-> ($fell(cclk_o) || $past(load_i)));
  // R7: a byte is never loaded over one still being shifted
  p_load_idle_r7: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !active_q);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int HAS_INIT     = 1,
  parameter int PULSE_CYC    = 125,
  parameter int INIT_TMO_CYC = 250_000_000,
  parameter int LAT_CYC      = 1_875_000,
  parameter int DONE_TMO_CYC = 25_000_000,
  parameter int CNT_W        = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic       cclk_o,
  output logic       din_o,
  output logic       prog_n_o,
  input  logic       init_n_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       fin_o,
  output logic [2:0] status_o
);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_END  = CNT_W'(INIT_TMO_CYC - 1);
  localparam logic [CNT_W-1:0] LAT_END   = CNT_W'(LAT_CYC - 1);
  localparam logic [CNT_W-1:0] DONE_LIM  = CNT_W'(DONE_TMO_CYC);

  cfg_fsm_e         st_q;
  cfg_status_e      status_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prog_n_q, busy_q, fin_q, dflag_q, xflag_q;
  logic             init_s, done_s, sh_rdy, sh_ld, tmo_hit;
  logic [7:0]       sh_byte;
  logic [1:0]       sync_q;

  cfg_sync #(.W(2)) u_sync (
    .clk(clk), .rst(rst), .d_i({init_n_i, done_i}), .q_o(sync_q)
  );
  assign init_s = sync_q[1];
  assign done_s = sync_q[0];

  assign s_ready_o = (st_q == S_DATA) && sh_rdy;
  assign sh_ld     = (s_ready_o && s_valid_i) || ((st_q == S_PADGO) && sh_rdy);
  assign sh_byte   = (st_q == S_PADGO) ? 8'hFF : s_data_i;
  assign tmo_hit   = (cnt_q >= DONE_LIM);

  cfg_shifter #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .load_i(sh_ld), .byte_i(sh_byte),
    .ready_o(sh_rdy), .cclk_o(cclk_o), .din_o(din_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      status_q <= ST_OK;
      cnt_q    <= '0;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      fin_q    <= 1'b0;
      dflag_q  <= 1'b0;
      xflag_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (partial_i) begin
            status_q <= ST_UNSUP;
            fin_q    <= 1'b1;
          end else begin
            prog_n_q <= 1'b0;
            cnt_q    <= '0;
            busy_q   <= 1'b1;
            st_q     <= S_PROG;
          end
        end
        S_PROG: begin
          if (HAS_INIT != 0) begin
            if (!init_s) begin
              prog_n_q <= 1'b1;
              cnt_q    <= '0;
              st_q     <= S_INITHI;
            end else if (cnt_q == INIT_END) begin
              prog_n_q <= 1'b1;
              status_q <= ST_INIT_TMO;
              fin_q    <= 1'b1;
              busy_q   <= 1'b0;
              st_q     <= S_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == PULSE_END) begin
              prog_n_q <= 1'b1;
              st_q     <= S_CHKDONE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_INITHI: begin
          if (init_s) begin
            st_q <= S_CHKDONE;
          end else if (cnt_q == INIT_END) begin
            status_q <= ST_INIT_TMO;
            fin_q    <= 1'b1;
            busy_q   <= 1'b0;
            st_q     <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_CHKDONE: begin
          if (done_s) begin
            status_q <= ST_IO_ERR;
            fin_q    <= 1'b1;
            busy_q   <= 1'b0;
            st_q     <= S_IDLE;
          end else begin
            cnt_q <= '0;
            st_q  <= S_LAT;
          end
        end
        S_LAT: begin
          if (cnt_q == LAT_END) st_q <= S_DATA;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_DATA: begin
          if (s_ready_o && s_valid_i && s_last_i) begin
            cnt_q <= '0;
            st_q  <= S_PADGO;
          end
        end
        S_PADGO: begin
          if (!tmo_hit) cnt_q <= cnt_q + 1'b1;
          if (sh_rdy) begin
            dflag_q <= done_s;
            xflag_q <= tmo_hit;
            st_q    <= S_PADWAIT;
          end
        end
        S_PADWAIT: begin
          if (!tmo_hit) cnt_q <= cnt_q + 1'b1;
          if (sh_rdy) begin
            if (dflag_q) begin
              status_q <= ST_OK;
              fin_q    <= 1'b1;
              busy_q   <= 1'b0;
              st_q     <= S_IDLE;
            end else if (xflag_q) begin
              if (HAS_INIT == 0)  status_q <= ST_TMO;
              else if (!init_s)   status_q <= ST_CRC;
              else                status_q <= ST_TRUNC;
              fin_q  <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= S_IDLE;
            end else begin
              st_q <= S_PADGO;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign prog_n_o = prog_n_q;
  assign busy_o   = busy_q;
  assign fin_o    = fin_q;
  assign status_o = status_q;

  // R1: program only falls after a full (non-partial) start request
  p_prog_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_n_o) |-> ($past(start_i) && !$past(partial_i)));
  // R2: no byte is taken while the device is held in program
  p_no_data_in_prog_r2: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> prog_n_o);
  // R4: an init timeout never leaves program asserted
  p_init_tmo_release_r4: assert property (@(posedge clk) disable iff (rst)
    (fin_o && status_o == ST_INIT_TMO) |-> prog_n_o);
  // R10: finish lasts one cycle
  p_fin_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !fin_o);
  // R10: the result moves only together with the finish pulse
  p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_o) |-> fin_o);
endmodule

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
  localparam int DIV = 4, PULSE = 8, INIT_TMO = 200, LAT = 50, DONE_TMO = 300;

  typedef struct packed {
    logic       partial;
    logic [3:0] n;
    logic [1:0] imode;   // 0 normal, 1 never low, 2 stuck low, 3 low after data
    logic       early;   // DONE high before the load
    logic [7:0] k;       // DONE rises after k pads; 255 = never
    logic [2:0] exp;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{1'b0, 4'd3, 2'd0, 1'b0, 8'd0,   3'd0},
    '{1'b0, 4'd5, 2'd0, 1'b0, 8'd2,   3'd0},
    '{1'b1, 4'd2, 2'd0, 1'b0, 8'd0,   3'd1},
    '{1'b0, 4'd2, 2'd1, 1'b0, 8'd255, 3'd2},
    '{1'b0, 4'd2, 2'd2, 1'b0, 8'd255, 3'd2},
    '{1'b0, 4'd2, 2'd0, 1'b1, 8'd255, 3'd3},
    '{1'b0, 4'd2, 2'd3, 1'b0, 8'd255, 3'd4},
    '{1'b0, 4'd3, 2'd0, 1'b0, 8'd255, 3'd5},
    '{1'b0, 4'd1, 2'd0, 1'b0, 8'd1,   3'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic start = 0, partial = 0, sv = 0, sl = 0;
  logic [7:0] sd = '0;
  logic sr, cclk, din, prog_n, init_n, done, busy, fin;
  logic [2:0] status;

  logic n_start = 0, n_sv = 0, n_sl = 0;
  logic [7:0] n_sd = '0;
  logic n_sr, n_cclk, n_din, n_prog, n_busy, n_fin;
  logic [2:0] n_status;

  int total = 0, bad = 0;

  // device model controls
  logic mdl_clr = 0;
  int m_n = 0, m_k = 255, m_imode = 0;
  logic m_early = 0;

  int cyc = 0, rx_cnt = 0, prog_falls = 0, first_rise = -1, init_rise = -1;
  int last_rise = 0, per_err = 0, acc_cnt = 0, last_acc = 0, n_low = 0;
  logic [7:0] rx [0:15];
  logic [7:0] rsh = '0;
  logic [2:0] rbit = '0;
  logic [3:0] pd = 4'hF;
  logic cclk_q = 0, prog_q = 1, init_q = 1;

  assign init_n = (m_imode == 2) ? 1'b0 :
                  (m_imode == 1) ? 1'b1 :
                  (m_imode == 3 && rx_cnt >= m_n) ? 1'b0 : pd[3];
  assign done = m_early | ((m_k != 255) && (rx_cnt >= m_n + m_k));

  cfg_loader #(.CLK_DIV(DIV), .HAS_INIT(1), .PULSE_CYC(PULSE), .INIT_TMO_CYC(INIT_TMO),
               .LAT_CYC(LAT), .DONE_TMO_CYC(DONE_TMO), .CNT_W(16)) i_cfg_loader (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial),
    .s_data_i(sd), .s_valid_i(sv), .s_last_i(sl), .s_ready_o(sr),
    .cclk_o(cclk), .din_o(din), .prog_n_o(prog_n), .init_n_i(init_n), .done_i(done),
    .busy_o(busy), .fin_o(fin), .status_o(status));

  cfg_loader #(.CLK_DIV(DIV), .HAS_INIT(0), .PULSE_CYC(PULSE), .INIT_TMO_CYC(INIT_TMO),
               .LAT_CYC(LAT), .DONE_TMO_CYC(DONE_TMO), .CNT_W(16)) i_cfg_loader_ni (
    .clk(clk), .rst(rst), .start_i(n_start), .partial_i(1'b0),
    .s_data_i(n_sd), .s_valid_i(n_sv), .s_last_i(n_sl), .s_ready_o(n_sr),
    .cclk_o(n_cclk), .din_o(n_din), .prog_n_o(n_prog), .init_n_i(1'b0), .done_i(1'b0),
    .busy_o(n_busy), .fin_o(n_fin), .status_o(n_status));

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    cclk_q <= cclk;
    prog_q <= prog_n;
    init_q <= init_n;
    pd     <= rst ? 4'hF : {pd[2:0], prog_n};
    if (!n_prog) n_low <= n_low + 1;
    if (mdl_clr) begin
      rbit <= '0; rx_cnt <= 0; prog_falls <= 0; first_rise <= -1; init_rise <= -1;
      per_err <= 0; acc_cnt <= 0; last_acc <= 0;
    end else begin
      if (cclk && !cclk_q) begin
        rsh       <= {rsh[6:0], din};
        rbit      <= rbit + 3'd1;
        last_rise <= cyc;
        if (rbit != 0 && cyc - last_rise != 2 * DIV) per_err <= per_err + 1;
        if (rbit == 3'd7) begin
          rx[rx_cnt % 16] <= {rsh[6:0], din};
          rx_cnt <= rx_cnt + 1;
        end
        if (first_rise < 0) first_rise <= cyc;
      end
      if (!prog_n && prog_q) prog_falls <= prog_falls + 1;
      if (init_n && !init_q) init_rise <= cyc;
      if (sv && sr) begin acc_cnt <= acc_cnt + 1; last_acc <= cyc; end
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'h12 + 8'(i * 8'h31);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int fin_cyc;
    logic [2:0] held;
    bit pulsed;
    fin_cyc = -1; pulsed = 0;
    @(negedge clk);
    mdl_clr = 1; m_n = int'(v.n); m_k = int'(v.k); m_imode = int'(v.imode); m_early = v.early;
    @(negedge clk);
    mdl_clr = 0;
    start = 1; partial = v.partial;
    @(negedge clk);
    start = 0; partial = 0;
    for (int t = 0; t < 6000; t++) begin
      if (fin) begin fin_cyc = cyc; break; end
      start = 1'b0;
      if (!v.partial && (t == 10 || (acc_cnt == 1 && !pulsed))) begin
        start = 1'b1;
        if (acc_cnt == 1) pulsed = 1;
      end
      if (!v.partial && acc_cnt < m_n) begin
        sv = 1; sd = pat(acc_cnt); sl = (acc_cnt == m_n - 1);
      end else begin
        sv = 0; sl = 0;
      end
      @(negedge clk);
    end
    start = 0; sv = 0; sl = 0;
    chk(fin_cyc >= 0, "R10", fin_cyc, 1);
    if (v.exp == 3'd0)      chk(status == v.exp, "R8",  int'(status), int'(v.exp));
    else if (v.exp == 3'd1) chk(status == v.exp, "R1",  int'(status), int'(v.exp));
    else if (v.exp == 3'd2) chk(status == v.exp, "R4",  int'(status), int'(v.exp));
    else if (v.exp == 3'd3) chk(status == v.exp, "R5",  int'(status), int'(v.exp));
    else                    chk(status == v.exp, "R9",  int'(status), int'(v.exp));
    // one program pulse per accepted load, none for a rejected one; repeat starts ignored
    chk(prog_falls == (v.partial ? 0 : 1), "R10", prog_falls, v.partial ? 0 : 1);
    chk(prog_n == 1'b1, "R4", int'(prog_n), 1);
    if (v.partial || v.exp == 3'd3 || v.exp == 3'd2)
      chk(rx_cnt == 0, "R5", rx_cnt, 0);
    if (v.exp == 3'd0) begin
      for (int i = 0; i < m_n; i++)
        chk(rx[i] == pat(i), "R7", int'(rx[i]), int'(pat(i)));
      chk(rx_cnt - m_n == m_k + 1, "R8", rx_cnt - m_n, m_k + 1);
      chk(first_rise - init_rise >= LAT, "R6", first_rise - init_rise, LAT);
      chk(per_err == 0, "R7", per_err, 0);
    end
    if (v.exp >= 3'd4) begin
      chk(fin_cyc - last_acc >= DONE_TMO, "R9", fin_cyc - last_acc, DONE_TMO);
      chk(rx_cnt - m_n >= 2, "R9", rx_cnt - m_n, 2);
    end
    held = status;
    repeat (30) @(negedge clk);
    chk(status == held, "R10", int'(status), int'(held));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    chk(prog_n == 1 && cclk == 0 && busy == 0 && fin == 0 && sr == 0 && status == 0,
        "R11", {prog_n, cclk, busy, fin, sr, status}, 8'b10000000);
    foreach (VEC[i]) run(VEC[i]);

    // R3: no init line; its input tied low must not stall the load
    n_low = 0;
    @(negedge clk); n_start = 1;
    @(negedge clk); n_start = 0;
    for (int t = 0; t < 2000 && !n_sr; t++) @(negedge clk);
    n_sv = 1; n_sl = 1; n_sd = 8'h81;
    @(negedge clk); n_sv = 0; n_sl = 0;
    for (int t = 0; t < 3000 && !n_fin; t++) @(negedge clk);
    chk(n_low == PULSE, "R3", n_low, PULSE);
    chk(n_fin == 1 && n_status == 3'd6, "R9", int'(n_status), 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule